// File: doc/BRIEF.md
# Multi-Bank Clock Divider

The block takes one fast source clock and produces three output banks (A, B and C, four outputs each) and a feedback output. Each of these is an even division of the source clock. Each bank has its own select code. A shared range bit picks between a low table and a high table, and the high table divides by half as much. All divided clocks begin together when the master reset is released, so they have a common rising edge. After that they return to a common phase every time all of their cycles end on the same source edge. The system integrator supplies the source clock. In bypass operation that is the reference clock itself. Every divider is a plain counter, so the block works at any source rate, down to a stopped clock.

A new select code or range bit is not applied at once. The block holds it until the next cycle boundary that all four dividers share, so no output ever produces a shortened high or low phase. One control input inverts the upper half of bank C relative to its lower half. This control is sampled on every source edge and needs no boundary. An active-low master reset clears all dividers. While it is low, every output is held at 0 with its enable flag cleared. The enable flags stand in for the output drivers that would otherwise float the pins.

Top module: `mbank_clkdiv`

## Requirements
- R1: Bank A divides the source by 8, 12, 16 or 24 for `sel_a` = 0, 1, 2, 3 with `range_hi`=0. With `range_hi`=1 it divides by 4, 6, 8 or 12. All four `qa` bits carry the same clock.
- R2: Bank B divides by 8, 12, 16 or 20 for `sel_b` = 0, 1, 2, 3 with `range_hi`=0. With `range_hi`=1 it divides by 4, 6, 8 or 10. All four `qb` bits carry the same clock.
- R3: Bank C outputs `qc[1:0]` divide by 4, 8, 12 or 16 for `sel_c` = 0, 1, 2, 3 with `range_hi`=0. With `range_hi`=1 they divide by 2, 4, 6 or 8.
- R4: `fb` divides by 8, 12, 16, 20, 16, 24, 32 or 40 for `sel_fb` = 0 to 7 with `range_hi`=0. With `range_hi`=1 it divides by 4, 6, 8, 10, 8, 12, 16 or 20.
- R5: Every output of divide ratio N is high for N/2 source cycles and then low for N/2 cycles. On the first source rising edge after `rst_n` goes high, every output goes high.
- R6: When `inv_c` is 0, `qc[3:2]` equal `qc[1:0]`. When it is 1, they are the complement of `qc[1:0]`. The value in effect is the one sampled on the most recent source edge.
- R7: While `rst_n` is 0, every clock output and every enable flag is 0, at once and without a clock edge. Reset also clears all divider state.
- R8: Select and range inputs are captured on the start edge. After that they are captured only on the source edge where every divider ends its cycle at the same time. A change at any other time leaves every output unchanged until that edge.
- R9: After the start edge, and until the next reset, every enable flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock (reference clock in bypass) |
| rst_n | input | 1 | Active-low master reset and output disable, asynchronous |
| range_hi | input | 1 | 1 selects the high-range tables (half the ratio) |
| sel_a | input | 2 | Bank A ratio select |
| sel_b | input | 2 | Bank B ratio select |
| sel_c | input | 2 | Bank C ratio select |
| sel_fb | input | 3 | Feedback ratio select |
| inv_c | input | 1 | 1 inverts qc[3:2] against qc[1:0] |
| qa | output | 4 | Bank A clocks |
| qa_en | output | 4 | Bank A enable flags |
| qb | output | 4 | Bank B clocks |
| qb_en | output | 4 | Bank B enable flags |
| qc | output | 4 | Bank C clocks |
| qc_en | output | 4 | Bank C enable flags |
| fb | output | 1 | Feedback clock |
| fb_en | output | 1 | Feedback enable flag |

## Verification
A select change can arrive on the very source edge where all dividers end their cycles together. On that edge the reload and the counter restart fall in the same cycle. The bench provokes this by watching its own phase model and changing `sel_a` while the model stands one cycle before the common boundary. The result is judged on the following cycles: the new ratio must apply from the restart, with no truncated phase. The same run also changes selects away from the boundary, and there the old ratios must continue unchanged.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  localparam int HALF_W = 5;

  function automatic int unsigned scale(input int unsigned base, input logic hi);
    return hi ? base / 4 : base / 2;
  endfunction

  function automatic int unsigned half_a(input logic hi, input logic [1:0] s);
    int unsigned b;
    case (s)
      2'd0: b = 8;
      2'd1: b = 12;
      2'd2: b = 16;
      default: b = 24;
    endcase
    return scale(b, hi);
  endfunction

  function automatic int unsigned half_b(input logic hi, input logic [1:0] s);
    int unsigned b;
    case (s)
      2'd0: b = 8;
      2'd1: b = 12;
      2'd2: b = 16;
      default: b = 20;
    endcase
    return scale(b, hi);
  endfunction

  function automatic int unsigned half_c(input logic hi, input logic [1:0] s);
    return scale(4 * (32'(s) + 1), hi);
  endfunction

  function automatic int unsigned half_f(input logic hi, input logic [2:0] s);
    int unsigned b;
    case (s[1:0])
      2'd0: b = 8;
      2'd1: b = 12;
      2'd2: b = 16;
      default: b = 20;
    endcase
    if (s[2]) b = b * 2;
    return scale(b, hi);
  endfunction
endpackage

// File: rtl/mbd_divider.sv
module mbd_divider #(
  parameter int HW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] half,
  input  logic          invert,
  output logic          q,
  output logic          wrap
);
  localparam int CW = HW + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nx;
  logic [CW-1:0] last;

  assign last   = {half, 1'b0} - CW'(1);
  assign wrap   = run && (cnt == last);
  assign cnt_nx = wrap ? '0 : cnt + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      q   <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      q   <= ~invert;
    end else begin
      cnt <= cnt_nx;
      q   <= (cnt_nx < {1'b0, half}) ^ invert;
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= last));

  // R5
  edge_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$stable(q) && ($past(invert) == $past(invert, 2)))
      |-> (cnt == '0 || cnt == {1'b0, half}));
endmodule

// File: rtl/mbd_ratio_ctl.sv
module mbd_ratio_ctl
  import mbd_pkg::*;
#(
  parameter int HW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          range_hi,
  input  logic [1:0]    sel_a,
  input  logic [1:0]    sel_b,
  input  logic [1:0]    sel_c,
  input  logic [2:0]    sel_fb,
  input  logic          wrap_all,
  output logic          run,
  output logic [HW-1:0] h_a,
  output logic [HW-1:0] h_b,
  output logic [HW-1:0] h_c,
  output logic [HW-1:0] h_f
);
  logic load;
  assign load = !run || wrap_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      h_a <= HW'(1);
      h_b <= HW'(1);
      h_c <= HW'(1);
      h_f <= HW'(1);
    end else begin
      run <= 1'b1;
      if (load) begin
        h_a <= HW'(half_a(range_hi, sel_a));
        h_b <= HW'(half_b(range_hi, sel_b));
        h_c <= HW'(half_c(range_hi, sel_c));
        h_f <= HW'(half_f(range_hi, sel_fb));
      end
    end
  end

  // R8
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(wrap_all))
      |-> ($stable(h_a) && $stable(h_b) && $stable(h_c) && $stable(h_f)));

  // R8
  half_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (h_a != '0 && h_b != '0 && h_c != '0 && h_f != '0));
endmodule

// File: rtl/mbank_clkdiv.sv
module mbank_clkdiv
  import mbd_pkg::*;
#(
  parameter int HW    = HALF_W,
  parameter int NBANK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             range_hi,
  input  logic [1:0]       sel_a,
  input  logic [1:0]       sel_b,
  input  logic [1:0]       sel_c,
  input  logic [2:0]       sel_fb,
  input  logic             inv_c,
  output logic [NBANK-1:0] qa,
  output logic [NBANK-1:0] qa_en,
  output logic [NBANK-1:0] qb,
  output logic [NBANK-1:0] qb_en,
  output logic [NBANK-1:0] qc,
  output logic [NBANK-1:0] qc_en,
  output logic             fb,
  output logic             fb_en
);
  localparam int NDIV   = 5;
  localparam int CLO    = NBANK / 2;
  localparam int D_A    = 0;
  localparam int D_B    = 1;
  localparam int D_C    = 2;
  localparam int D_CHI  = 3;
  localparam int D_F    = 4;

  logic                run;
  logic                wrap_all;
  logic [HW-1:0]       h_a, h_b, h_c, h_f;
  logic [NDIV-1:0]     dq;
  logic [NDIV-1:0]     dwrap;
  logic [HW-1:0]       dhalf [NDIV];
  logic [NDIV-1:0]     dinv;

  assign dhalf[D_A]   = h_a;
  assign dhalf[D_B]   = h_b;
  assign dhalf[D_C]   = h_c;
  assign dhalf[D_CHI] = h_c;
  assign dhalf[D_F]   = h_f;
  assign dinv         = NDIV'(inv_c) << D_CHI;

  // The upper bank-C divider mirrors the lower one, so its wrap adds nothing.
  assign wrap_all = dwrap[D_A] & dwrap[D_B] & dwrap[D_C] & dwrap[D_F];

  mbd_ratio_ctl #(.HW(HW)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .range_hi (range_hi),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .sel_c    (sel_c),
    .sel_fb   (sel_fb),
    .wrap_all (wrap_all),
    .run      (run),
    .h_a      (h_a),
    .h_b      (h_b),
    .h_c      (h_c),
    .h_f      (h_f)
  );

  for (genvar i = 0; i < NDIV; i++) begin : g_div
    mbd_divider #(.HW(HW)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .half   (dhalf[i]),
      .invert (dinv[i]),
      .q      (dq[i]),
      .wrap   (dwrap[i])
    );
  end

  assign qa    = {NBANK{dq[D_A]}};
  assign qb    = {NBANK{dq[D_B]}};
  assign qc    = {{(NBANK - CLO){dq[D_CHI]}}, {CLO{dq[D_C]}}};
  assign fb    = dq[D_F];
  assign qa_en = {NBANK{run}};
  assign qb_en = {NBANK{run}};
  assign qc_en = {NBANK{run}};
  assign fb_en = run;

  // R7
  disabled_chk: assert property (@(posedge clk)
    !rst_n |-> (qa == '0 && qb == '0 && qc == '0 && !fb &&
                qa_en == '0 && qb_en == '0 && qc_en == '0 && !fb_en));

  // R5
  common_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || wrap_all) |=> (dq[D_A] && dq[D_B] && dq[D_C] && dq[D_F]));

  // R6
  inv_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (dq[D_CHI] == (dq[D_C] ^ $past(inv_c))));
endmodule

// File: tb/tb_mbank_clkdiv.sv
`timescale 1ns/1ps
module tb_mbank_clkdiv;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       range_hi = 1'b0;
  logic [1:0] sel_a = '0, sel_b = '0, sel_c = '0;
  logic [2:0] sel_fb = '0;
  logic       inv_c = 1'b0;
  logic [3:0] qa, qa_en, qb, qb_en, qc, qc_en;
  logic       fb, fb_en;

  mbank_clkdiv dut (
    .clk(clk), .rst_n(rst_n), .range_hi(range_hi), .sel_a(sel_a), .sel_b(sel_b),
    .sel_c(sel_c), .sel_fb(sel_fb), .inv_c(inv_c), .qa(qa), .qa_en(qa_en),
    .qb(qb), .qb_en(qb_en), .qc(qc), .qc_en(qc_en), .fb(fb), .fb_en(fb_en)
  );

  always #2.5 clk = ~clk;

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;
  int  na, nb, nc, nf, k, per;
  bit  running = 0, inv_m = 0;

  // vector: {range_hi, sel_a, sel_b, sel_c, sel_fb, inv_c}
  localparam logic [10:0] VEC [10] = '{
    {1'b0, 2'd0, 2'd0, 2'd0, 3'd0, 1'b0},
    {1'b1, 2'd0, 2'd0, 2'd0, 3'd0, 1'b1},
    {1'b0, 2'd1, 2'd1, 2'd1, 3'd1, 1'b0},
    {1'b1, 2'd1, 2'd2, 2'd3, 3'd5, 1'b1},
    {1'b0, 2'd2, 2'd2, 2'd2, 3'd2, 1'b1},
    {1'b1, 2'd3, 2'd3, 2'd3, 3'd3, 1'b0},
    {1'b0, 2'd3, 2'd3, 2'd3, 3'd7, 1'b0},
    {1'b1, 2'd2, 2'd1, 2'd0, 3'd4, 1'b0},
    {1'b0, 2'd0, 2'd3, 2'd1, 3'd6, 1'b1},
    {1'b1, 2'd3, 2'd0, 2'd2, 3'd7, 1'b1}
  };

  function automatic int ra(bit h, int s);
    int t[4] = '{8, 12, 16, 24};
    return h ? t[s] / 2 : t[s];
  endfunction
  function automatic int rb(bit h, int s);
    int t[4] = '{8, 12, 16, 20};
    return h ? t[s] / 2 : t[s];
  endfunction
  function automatic int rc(bit h, int s);
    int t[4] = '{4, 8, 12, 16};
    return h ? t[s] / 2 : t[s];
  endfunction
  function automatic int rf(bit h, int s);
    int t[8] = '{8, 12, 16, 20, 16, 24, 32, 40};
    return h ? t[s] / 2 : t[s];
  endfunction
  function automatic int gcd(int x, int y);
    while (y != 0) begin
      int t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction
  function automatic int lcm(int x, int y);
    return x / gcd(x, y) * y;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, act, exp);
    end
  endtask

  function automatic logic ph(int n);
    return (k % n) < (n / 2);
  endfunction

  task automatic check_now();
    logic a, b, c, f;
    if (!running) begin
      chk("R7 disabled clocks", {qa | qb | qc, fb}, 4'h0);
      chk("R7 disabled enables", {qa_en | qb_en | qc_en, fb_en}, 4'h0);
    end else begin
      a = ph(na); b = ph(nb); c = ph(nc); f = ph(nf);
      chk("R1 bank A", qa, {4{a}});
      chk("R2 bank B", qb, {4{b}});
      chk("R3 bank C low", {2'b00, qc[1:0]}, {2'b00, {2{c}}});
      chk("R4 feedback", {3'b000, fb}, {3'b000, f});
      chk("R6 bank C high", {2'b00, qc[3:2]}, {2'b00, {2{c ^ inv_m}}});
      chk("R9 enables", qa_en & qb_en & qc_en & {4{fb_en}}, 4'hF);
    end
  endtask

  task automatic load_model();
    na = ra(range_hi, sel_a);
    nb = rb(range_hi, sel_b);
    nc = rc(range_hi, sel_c);
    nf = rf(range_hi, sel_fb);
    per = lcm(lcm(na, nb), lcm(nc, nf));
  endtask

  // Called after a negedge check, before the next posedge samples inputs.
  task automatic advance();
    if (!rst_n) running = 0;
    else if (!running) begin
      running = 1; k = 0; load_model();
    end else if (k == per - 1) begin
      k = 0; load_model();
    end else k++;
    inv_m = inv_c;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_n(int n);
    for (int i = 0; i < n; i++) begin
      check_now();
      advance();
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    running = 0;
    check_now();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    @(negedge clk);
    check_now();                       // R7 reset state
    for (int v = 0; v < 10; v++) begin
      do_reset();
      {range_hi, sel_a, sel_b, sel_c, sel_fb, inv_c} = VEC[v];
      rst_n = 1'b1;
      check_now();
      advance();
      // R5: first edge after release raises every output
      chk("R5 common rise", {qa[0], qb[0], qc[0], fb}, 4'hF);
      run_n(2 * per + 3);
    end

    // R8: change away from the boundary, then exactly on it
    do_reset();
    {range_hi, sel_a, sel_b, sel_c, sel_fb, inv_c} = {1'b0, 2'd0, 2'd0, 2'd0, 3'd0, 1'b0};
    rst_n = 1'b1;
    run_n(3);
    sel_a = 2'd3; sel_fb = 3'd2;       // R8 mid-period change
    run_n(per + 4);
    while (k != per - 2) run_n(1);
    check_now();
    sel_a = 2'd1; range_hi = 1'b1;     // R8 lands on common boundary edge
    advance();
    run_n(2 * per + 2);

    // R6: toggle inversion while running
    for (int i = 0; i < 6; i++) begin
      inv_c = ~inv_c;
      run_n(3);
    end

    // R7: mid-run reset acts without a clock edge
    @(posedge clk);
    #1.2;
    rst_n = 1'b0;
    #0.3;
    chk("R7 async clocks", {qa | qb | qc, fb}, 4'h0);
    chk("R7 async enables", {qa_en | qb_en | qc_en, fb_en}, 4'h0);
    @(negedge clk);
    running = 0;
    run_n(3);
    rst_n = 1'b1;
    run_n(40);
    summary();
  end
endmodule